// File: doc/BRIEF.md
# Wire-Side Event Frame Timestamper

This block sits beside the 4-bit media-independent interface between an Ethernet MAC and its PHY and watches both directions without touching either. When a frame crosses the wire it notes the value of an externally supplied free-running time counter at the start-of-frame delimiter nibble. It then follows the frame header, checks for the precision-time-protocol EtherType and decodes the message type. Only the time-critical event messages (Sync, DelayReq, PdelayReq, PdelayResp) publish their captured time. FollowUp, DelayResp and PdelayRespFollowUp frames, and non-PTP frames, discard it.

Receive and transmit each own a timestamp latch with a valid flag, a sticky overrun flag and a clear strobe. A small layout register picks how the message type is found: the older (2002) layout, the newer (2008) layout, or a mode that stamps every frame in either direction. The 2002 layout is selected out of reset. The MII nibbles are sampled on the block clock, one nibble per cycle while the data-valid line is high.

Top module: `ptp_wire_stamper`

## Requirements
- R1: After synchronous reset both valid flags and both overrun flags are 0, both stamps are 0 and the layout register holds 2'b00.
- R2: A frame starts only when data-valid is high for one or more 0x5 nibbles followed by a 0xD nibble. A 0xD with no 0x5 before it, or any other nibble in the preamble, ignores the rest of that frame. The candidate time is the `local_time` value sampled on the clock edge of the 0xD nibble.
- R3: Bytes are rebuilt from nibbles low nibble first, counting from byte 0 after the 0xD. A frame is PTP only when byte 12 is 0x88 and byte 13 is 0xF7.
- R4: With layout 2'b01, a PTP frame publishes its candidate time when the low 4 bits of byte 14 are 0 to 3. The valid flag rises one cycle after the high nibble of byte 14 is sampled. The codes 0x8, 0x9 and 0xA never publish.
- R5: With layout 2'b00, a PTP frame publishes when byte 46 (payload offset 32) is 0x00 or 0x01. The codes 0x02 and 0x03 never publish. The flag rises one cycle after the high nibble of byte 46.
- R6: With layout 2'b10 or 2'b11, every started frame publishes, whatever its content. The valid flag rises one cycle after the 0xD nibble.
- R7: A published stamp and its valid flag hold until the clear strobe for that direction. A clear lowers valid and overrun on the next cycle and leaves the stamp value unchanged.
- R8: An event arriving while valid is held and no clear is given sets the sticky overrun flag and keeps the old stamp. A clear in the same cycle as an event loads the new stamp, keeps valid high and leaves overrun 0.
- R9: Data-valid going low ends the current frame at once. A frame cut before its deciding byte publishes nothing.
- R10: The receive and transmit paths are fully independent; frames in both directions at the same time each get their own stamp.
- R11: `mode_we` loads `mode_wdata` into the layout register. Each frame uses the layout the register held at its 0xD nibble, so a change during a frame has no effect on that frame.
- R12: With layout 2'b00 or 2'b01, a frame whose EtherType is not 0x88F7 publishes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; MII nibbles sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load strobe for the layout register |
| mode_wdata | input | 2 | Layout: 00 = 2002, 01 = 2008, 1x = all frames |
| local_time | input | TIME_W | Free-running local time counter |
| rx_dv | input | 1 | Receive data-valid |
| rx_nib | input | 4 | Receive data nibble |
| tx_en | input | 1 | Transmit enable |
| tx_nib | input | 4 | Transmit data nibble |
| rx_clr | input | 1 | Clear receive valid and overrun |
| tx_clr | input | 1 | Clear transmit valid and overrun |
| rx_stamp | output | TIME_W | Receive timestamp |
| rx_stamp_vld | output | 1 | Receive timestamp held |
| rx_ovr | output | 1 | Receive event lost while held |
| tx_stamp | output | TIME_W | Transmit timestamp |
| tx_stamp_vld | output | 1 | Transmit timestamp held |
| tx_ovr | output | 1 | Transmit event lost while held |

## Verification
Frames of each layout carry event codes and non-event codes, which separates correct type decoding from a decoder that stamps any PTP frame. A wrong EtherType, a byte-swapped EtherType and damaged preambles show whether matching is tied to the right bytes, the low-first nibble order and a real delimiter. Frames cut short, back-to-back events without a clear, and a clear timed into the publish cycle test the abandon, overrun and priority rules. Traffic in both directions at once in the all-frames mode, plus a layout change in the middle of a frame, show that the two paths are independent and that the layout is sampled per frame.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    localparam logic [3:0]  NIB_PREAMBLE = 4'h5;
    localparam logic [3:0]  NIB_DELIM    = 4'hD;
    localparam logic [7:0]  ETYPE_HI     = 8'h88;
    localparam logic [7:0]  ETYPE_LO     = 8'hF7;

    localparam int IDX_W        = 7;
    localparam int TYPE_HI_POS  = 12;
    localparam int TYPE_LO_POS  = 13;
    localparam int V2_TYPE_POS  = 14;
    localparam int V1_CTRL_OFF  = 32;
    localparam int V1_CTRL_POS  = V2_TYPE_POS + V1_CTRL_OFF;

    typedef enum logic [1:0] {
        LAY_V2002 = 2'b00,
        LAY_V2008 = 2'b01,
        LAY_ALL_A = 2'b10,
        LAY_ALL_B = 2'b11
    } layout_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_PRE,
        FR_DATA,
        FR_DROP
    } fr_state_e;

    typedef struct packed {
        logic             stb;
        logic [IDX_W-1:0] idx;
        logic [7:0]       val;
    } byte_ev_t;

    function automatic logic is_all(input layout_e m);
        return m[1];
    endfunction

    function automatic logic v2008_event(input logic [3:0] code);
        return code <= 4'd3;
    endfunction

    function automatic logic v2002_event(input logic [7:0] ctrl);
        return ctrl <= 8'd1;
    endfunction

endpackage

// File: rtl/ptp_nib_framer.sv
module ptp_nib_framer
    import ptp_stamp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dv,
    input  logic [3:0] nib,
    output logic     sfd_stb,
    output byte_ev_t bev
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    fr_state_e        state;
    logic             half;
    logic [3:0]       low_nib;
    logic [IDX_W-1:0] idx;

    assign sfd_stb = dv && (state == FR_PRE) && (nib == NIB_DELIM);

    always_comb begin
        bev.stb = dv && (state == FR_DATA) && half;
        bev.idx = idx;
        bev.val = {nib, low_nib};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_IDLE;
            half    <= 1'b0;
            low_nib <= '0;
            idx     <= '0;
        end else if (!dv) begin
            state <= FR_IDLE;
            half  <= 1'b0;
        end else begin
            unique case (state)
                FR_IDLE: state <= (nib == NIB_PREAMBLE) ? FR_PRE : FR_DROP;
                FR_PRE: begin
                    if (nib == NIB_DELIM) begin
                        state <= FR_DATA;
                        half  <= 1'b0;
                        idx   <= '0;
                    end else if (nib != NIB_PREAMBLE) begin
                        state <= FR_DROP;
                    end
                end
                FR_DATA: begin
                    if (!half) begin
                        low_nib <= nib;
                        half    <= 1'b1;
                    end else begin
                        half <= 1'b0;
                        if (idx != IDX_MAX) idx <= idx + 1'b1;
                    end
                end
                default: state <= FR_DROP;
            endcase
        end
    end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
    import ptp_stamp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  layout_e  layout,
    input  logic     sfd_stb,
    input  byte_ev_t bev,
    output logic     pub_stb,
    output logic     pub_now
);
    localparam logic [IDX_W-1:0] P_HI   = IDX_W'(TYPE_HI_POS);
    localparam logic [IDX_W-1:0] P_LO   = IDX_W'(TYPE_LO_POS);
    localparam logic [IDX_W-1:0] P_V2   = IDX_W'(V2_TYPE_POS);
    localparam logic [IDX_W-1:0] P_V1   = IDX_W'(V1_CTRL_POS);

    layout_e frame_lay;
    logic    hi_ok;
    logic    type_ok;
    logic    hit_v2, hit_v1;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_lay <= LAY_V2002;
            hi_ok     <= 1'b0;
            type_ok   <= 1'b0;
        end else if (sfd_stb) begin
            frame_lay <= layout;
            hi_ok     <= 1'b0;
            type_ok   <= 1'b0;
        end else if (bev.stb) begin
            if (bev.idx == P_HI) hi_ok   <= (bev.val == ETYPE_HI);
            if (bev.idx == P_LO) type_ok <= hi_ok && (bev.val == ETYPE_LO);
        end
    end

    always_comb begin
        hit_v2 = bev.stb && type_ok && (frame_lay == LAY_V2008)
                 && (bev.idx == P_V2) && v2008_event(bev.val[3:0]);
        hit_v1 = bev.stb && type_ok && (frame_lay == LAY_V2002)
                 && (bev.idx == P_V1) && v2002_event(bev.val);
        pub_now = sfd_stb && is_all(layout);
        pub_stb = pub_now || hit_v2 || hit_v1;
    end
endmodule

// File: rtl/ptp_stamp_hold.sv
module ptp_stamp_hold #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sfd_stb,
    input  logic [TIME_W-1:0] time_in,
    input  logic              pub_stb,
    input  logic              pub_now,
    input  logic              clr,
    output logic [TIME_W-1:0] stamp,
    output logic              valid,
    output logic              ovr
);
    logic [TIME_W-1:0] cand;
    logic [TIME_W-1:0] cand_sel;

    assign cand_sel = pub_now ? time_in : cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand  <= '0;
            stamp <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (sfd_stb) cand <= time_in;
            if (pub_stb && (!valid || clr)) begin
                stamp <= cand_sel;
                valid <= 1'b1;
                ovr   <= 1'b0;
            end else if (pub_stb) begin
                ovr <= 1'b1;
            end else if (clr) begin
                valid <= 1'b0;
                ovr   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ptp_stamp_lane.sv
module ptp_stamp_lane
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  layout_e           layout,
    input  logic [TIME_W-1:0] local_time,
    input  logic              dv,
    input  logic [3:0]        nib,
    input  logic              clr,
    output logic              pub,
    output logic [TIME_W-1:0] stamp,
    output logic              valid,
    output logic              ovr
);
    logic     sfd_stb;
    byte_ev_t bev;
    logic     pub_now;

    ptp_nib_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .dv      (dv),
        .nib     (nib),
        .sfd_stb (sfd_stb),
        .bev     (bev)
    );

    ptp_evt_classifier u_class (
        .clk     (clk),
        .rst     (rst),
        .layout  (layout),
        .sfd_stb (sfd_stb),
        .bev     (bev),
        .pub_stb (pub),
        .pub_now (pub_now)
    );

    ptp_stamp_hold #(.TIME_W(TIME_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .sfd_stb (sfd_stb),
        .time_in (local_time),
        .pub_stb (pub),
        .pub_now (pub_now),
        .clr     (clr),
        .stamp   (stamp),
        .valid   (valid),
        .ovr     (ovr)
    );
endmodule

// File: rtl/ptp_wire_stamper.sv
module ptp_wire_stamper
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic [TIME_W-1:0] local_time,
    input  logic              rx_dv,
    input  logic [3:0]        rx_nib,
    input  logic              tx_en,
    input  logic [3:0]        tx_nib,
    input  logic              rx_clr,
    input  logic              tx_clr,
    output logic [TIME_W-1:0] rx_stamp,
    output logic              rx_stamp_vld,
    output logic              rx_ovr,
    output logic [TIME_W-1:0] tx_stamp,
    output logic              tx_stamp_vld,
    output logic              tx_ovr
);
    localparam int LANES = 2;

    layout_e           layout_q;
    logic              lane_dv  [LANES];
    logic [3:0]        lane_nib [LANES];
    logic              lane_clr [LANES];
    logic [TIME_W-1:0] lane_stp [LANES];
    logic              lane_vld [LANES];
    logic              lane_ovr [LANES];
    logic [LANES-1:0]  lane_pub;

    always_ff @(posedge clk) begin
        if (rst)          layout_q <= LAY_V2002;
        else if (mode_we) layout_q <= layout_e'(mode_wdata);
    end

    assign lane_dv[0]  = rx_dv;
    assign lane_nib[0] = rx_nib;
    assign lane_clr[0] = rx_clr;
    assign lane_dv[1]  = tx_en;
    assign lane_nib[1] = tx_nib;
    assign lane_clr[1] = tx_clr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ptp_stamp_lane #(.TIME_W(TIME_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .layout     (layout_q),
            .local_time (local_time),
            .dv         (lane_dv[g]),
            .nib        (lane_nib[g]),
            .clr        (lane_clr[g]),
            .pub        (lane_pub[g]),
            .stamp      (lane_stp[g]),
            .valid      (lane_vld[g]),
            .ovr        (lane_ovr[g])
        );
    end

    assign rx_stamp     = lane_stp[0];
    assign rx_stamp_vld = lane_vld[0];
    assign rx_ovr       = lane_ovr[0];
    assign tx_stamp     = lane_stp[1];
    assign tx_stamp_vld = lane_vld[1];
    assign tx_ovr       = lane_ovr[1];
endmodule

// File: rtl/ptp_wire_stamper_chk.sv
module ptp_wire_stamper_chk #(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        lane_pub,
    input logic              rx_clr,
    input logic              tx_clr,
    input logic [TIME_W-1:0] rx_stamp,
    input logic              rx_stamp_vld,
    input logic              rx_ovr,
    input logic [TIME_W-1:0] tx_stamp,
    input logic              tx_stamp_vld,
    input logic              tx_ovr
);
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: outputs idle in the cycle after reset
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            p_reset_idle_r1: assert (!rx_stamp_vld && !tx_stamp_vld && !rx_ovr && !tx_ovr);
        end
    end

    // R7: a held stamp does not move while no clear is given
    p_hold_rx_r7: assert property (@(posedge clk) disable iff (rst)
        rx_stamp_vld && !rx_clr |=> $stable(rx_stamp) && rx_stamp_vld);
    p_hold_tx_r7: assert property (@(posedge clk) disable iff (rst)
        tx_stamp_vld && !tx_clr |=> $stable(tx_stamp) && tx_stamp_vld);

    // R7: clear with no event drops valid and overrun
    p_clear_rx_r7: assert property (@(posedge clk) disable iff (rst)
        rx_clr && !lane_pub[0] |=> !rx_stamp_vld && !rx_ovr);
    p_clear_tx_r7: assert property (@(posedge clk) disable iff (rst)
        tx_clr && !lane_pub[1] |=> !tx_stamp_vld && !tx_ovr);

    // R8: overrun only with a held stamp, and sticky until cleared
    p_ovr_needs_vld_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_ovr -> rx_stamp_vld) && (tx_ovr -> tx_stamp_vld));
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        rx_ovr && !rx_clr |=> rx_ovr);
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
        lane_pub[0] && rx_stamp_vld && !rx_clr |=> rx_ovr);

    // R8: event with clear in the same cycle leaves a fresh, non-overrun stamp
    p_clr_evt_r8: assert property (@(posedge clk) disable iff (rst)
        lane_pub[1] && tx_clr |=> tx_stamp_vld && !tx_ovr);

    // R4/R6: a published event always leaves the lane valid
    p_pub_sets_r4: assert property (@(posedge clk) disable iff (rst)
        lane_pub[0] |=> rx_stamp_vld);
endmodule

bind ptp_wire_stamper ptp_wire_stamper_chk #(.TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .lane_pub     (lane_pub),
    .rx_clr       (rx_clr),
    .tx_clr       (tx_clr),
    .rx_stamp     (rx_stamp),
    .rx_stamp_vld (rx_stamp_vld),
    .rx_ovr       (rx_ovr),
    .tx_stamp     (tx_stamp),
    .tx_stamp_vld (tx_stamp_vld),
    .tx_ovr       (tx_ovr)
);

// File: tb/ptp_wire_stamper_test.sv
module ptp_wire_stamper_test;
    localparam int TW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_we = 1'b0;
    logic [1:0]    mode_wd = 2'b00;
    logic [TW-1:0] ltime = 64'h0000_1000_0000_0000;
    logic          dv_b  [2] = '{1'b0, 1'b0};
    logic [3:0]    nib_b [2] = '{4'h0, 4'h0};
    logic          clr_b [2] = '{1'b0, 1'b0};
    logic [TW-1:0] o_stp [2];
    logic          o_vld [2];
    logic          o_ovr [2];
    logic [TW-1:0] rx_stamp, tx_stamp;
    logic          rx_vld, tx_vld, rx_ovr, tx_ovr;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;
    always @(posedge clk) ltime <= ltime + 64'd7;

    ptp_wire_stamper #(.TIME_W(TW)) uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wd),
        .local_time(ltime),
        .rx_dv(dv_b[0]), .rx_nib(nib_b[0]), .tx_en(dv_b[1]), .tx_nib(nib_b[1]),
        .rx_clr(clr_b[0]), .tx_clr(clr_b[1]),
        .rx_stamp(rx_stamp), .rx_stamp_vld(rx_vld), .rx_ovr(rx_ovr),
        .tx_stamp(tx_stamp), .tx_stamp_vld(tx_vld), .tx_ovr(tx_ovr)
    );

    assign o_stp[0] = rx_stamp; assign o_vld[0] = rx_vld; assign o_ovr[0] = rx_ovr;
    assign o_stp[1] = tx_stamp; assign o_vld[1] = tx_vld; assign o_ovr[1] = tx_ovr;

    task automatic chk(input string req, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_st  [2];
    int            m_cnt [2];
    bit            m_half[2];
    logic [3:0]    m_lo  [2];
    logic [1:0]    m_fl  [2];
    logic [7:0]    m_fb  [2][64];
    logic [TW-1:0] m_cap [2];
    logic [TW-1:0] e_stp [2];
    bit            e_vld [2];
    bit            e_ovr [2];
    logic [1:0]    m_mode;
    bit            m_pub;
    logic [TW-1:0] m_pt;
    logic [7:0]    m_b;

    always @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < 2; d++) begin
                m_st[d] = 0; m_cnt[d] = 0; m_half[d] = 0; m_cap[d] = '0;
                e_stp[d] = '0; e_vld[d] = 0; e_ovr[d] = 0;
            end
            m_mode = 2'b00;
            cmp_en <= 1'b1;
        end else begin
            for (int d = 0; d < 2; d++) begin
                m_pub = 0;
                m_pt  = m_cap[d];
                if (!dv_b[d]) begin
                    m_st[d] = 0; m_half[d] = 0;
                end else begin
                    case (m_st[d])
                        0: m_st[d] = (nib_b[d] == 4'h5) ? 1 : 3;
                        1: begin
                            if (nib_b[d] == 4'hD) begin
                                m_st[d] = 2; m_half[d] = 0; m_cnt[d] = 0;
                                m_cap[d] = ltime; m_fl[d] = m_mode;
                                if (m_mode[1]) begin m_pub = 1; m_pt = ltime; end
                            end else if (nib_b[d] != 4'h5) begin
                                m_st[d] = 3;
                            end
                        end
                        2: begin
                            if (!m_half[d]) begin
                                m_lo[d] = nib_b[d]; m_half[d] = 1;
                            end else begin
                                m_half[d] = 0;
                                m_b = {nib_b[d], m_lo[d]};
                                if (m_cnt[d] < 64) m_fb[d][m_cnt[d]] = m_b;
                                m_cnt[d]++;
                                if (!m_fl[d][1] && m_cnt[d] >= 14 &&
                                    m_fb[d][12] == 8'h88 && m_fb[d][13] == 8'hF7) begin
                                    if (m_fl[d] == 2'b01 && m_cnt[d] == 15 && m_b[3:0] <= 4'd3)
                                        m_pub = 1;
                                    if (m_fl[d] == 2'b00 && m_cnt[d] == 47 && m_b <= 8'd1)
                                        m_pub = 1;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                if (m_pub && (!e_vld[d] || clr_b[d])) begin
                    e_stp[d] = m_pt; e_vld[d] = 1; e_ovr[d] = 0;
                end else if (m_pub) begin
                    e_ovr[d] = 1;
                end else if (clr_b[d]) begin
                    e_vld[d] = 0; e_ovr[d] = 0;
                end
            end
            if (mode_we) m_mode = mode_wd;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int d = 0; d < 2; d++) begin
                chk(cur_req, d ? "tx_stamp" : "rx_stamp", o_stp[d], e_stp[d]);
                chk(cur_req, d ? "tx_vld" : "rx_vld", {63'd0, o_vld[d]}, {63'd0, e_vld[d]});
                chk(cur_req, d ? "tx_ovr" : "rx_ovr", {63'd0, o_ovr[d]}, {63'd0, e_ovr[d]});
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int d, input logic [15:0] et, input logic [7:0] b14,
                        input logic [7:0] b46, input int nbytes, input int npre,
                        input logic [3:0] first_pre, input int clr_byte,
                        output logic [TW-1:0] t_sfd);
        logic [7:0] fr [64];
        for (int i = 0; i < 64; i++) fr[i] = 8'(i * 17 + 3);
        fr[12] = et[15:8]; fr[13] = et[7:0]; fr[14] = b14; fr[46] = b46;
        for (int i = 0; i < npre; i++) begin
            @(negedge clk); dv_b[d] = 1'b1; nib_b[d] = (i == 0) ? first_pre : 4'h5;
        end
        @(negedge clk); dv_b[d] = 1'b1; nib_b[d] = 4'hD; t_sfd = ltime;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk); nib_b[d] = fr[i][3:0]; clr_b[d] = 1'b0;
            @(negedge clk); nib_b[d] = fr[i][7:4]; clr_b[d] = (i == clr_byte);
        end
        @(negedge clk); dv_b[d] = 1'b0; nib_b[d] = 4'h0; clr_b[d] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear(input int d);
        @(negedge clk); clr_b[d] = 1'b1;
        @(negedge clk); clr_b[d] = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wd = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    initial begin
        logic [TW-1:0] t0, t1, t2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "rx_vld after reset", {63'd0, rx_vld}, 64'd0);
        chk("R1", "tx_stamp after reset", tx_stamp, 64'd0);
        chk("R1", "rx_ovr after reset", {63'd0, rx_ovr}, 64'd0);

        // R5: default layout 2002, Sync control code 0x00 on receive
        cur_req = "R5";
        send(0, 16'h88F7, 8'h02, 8'h00, 60, 7, 4'h5, -1, t0);
        chk("R5", "rx_vld v2002 sync", {63'd0, rx_vld}, 64'd1);
        chk("R5", "rx_stamp v2002 sync", rx_stamp, t0);
        clear(0);
        chk("R7", "rx_vld after clear", {63'd0, rx_vld}, 64'd0);
        chk("R7", "rx_stamp kept after clear", rx_stamp, t0);
        // R5: FollowUp-type control code 0x02 is not stamped
        send(0, 16'h88F7, 8'h00, 8'h02, 60, 7, 4'h5, -1, t1);
        chk("R5", "rx_vld v2002 code 2", {63'd0, rx_vld}, 64'd0);

        // R11 + R4: switch to 2008, DelayReq on transmit
        cur_req = "R4";
        set_mode(2'b01);
        send(1, 16'h88F7, 8'h01, 8'h55, 40, 3, 4'h5, -1, t0);
        chk("R4", "tx_vld v2008 code 1", {63'd0, tx_vld}, 64'd1);
        chk("R4", "tx_stamp v2008 code 1", tx_stamp, t0);
        clear(1);
        for (int c = 8; c <= 10; c++) begin
            send(1, 16'h88F7, 8'(8'h20 | c), 8'h00, 40, 3, 4'h5, -1, t1);
            chk("R4", "tx_vld v2008 general code", {63'd0, tx_vld}, 64'd0);
        end

        // R12: not a PTP EtherType
        cur_req = "R12";
        send(0, 16'h0800, 8'h00, 8'h00, 60, 5, 4'h5, -1, t1);
        chk("R12", "rx_vld other ethertype", {63'd0, rx_vld}, 64'd0);
        // R3: EtherType with bytes reversed
        cur_req = "R3";
        send(0, 16'hF788, 8'h00, 8'h00, 30, 5, 4'h5, -1, t1);
        chk("R3", "rx_vld swapped ethertype", {63'd0, rx_vld}, 64'd0);

        // R2: delimiter without preamble, and a corrupt preamble nibble
        cur_req = "R2";
        send(0, 16'h88F7, 8'h00, 8'h00, 30, 0, 4'h5, -1, t1);
        chk("R2", "rx_vld no preamble", {63'd0, rx_vld}, 64'd0);
        send(0, 16'h88F7, 8'h00, 8'h00, 30, 4, 4'h7, -1, t1);
        chk("R2", "rx_vld bad preamble", {63'd0, rx_vld}, 64'd0);

        // R9: frame cut before byte 14, then a good frame
        cur_req = "R9";
        send(0, 16'h88F7, 8'h00, 8'h00, 14, 5, 4'h5, -1, t1);
        chk("R9", "rx_vld cut frame", {63'd0, rx_vld}, 64'd0);
        send(0, 16'h88F7, 8'h03, 8'h00, 20, 5, 4'h5, -1, t0);
        chk("R9", "rx_stamp after cut frame", rx_stamp, t0);

        // R8: second event while held -> overrun, old stamp kept
        cur_req = "R8";
        send(0, 16'h88F7, 8'h00, 8'h00, 20, 5, 4'h5, -1, t1);
        chk("R8", "rx_ovr set", {63'd0, rx_ovr}, 64'd1);
        chk("R8", "rx_stamp held on overrun", rx_stamp, t0);
        // R8: clear in the publish cycle loads the new stamp
        send(0, 16'h88F7, 8'h02, 8'h00, 20, 5, 4'h5, 14, t2);
        chk("R8", "rx_stamp clear+event", rx_stamp, t2);
        chk("R8", "rx_ovr clear+event", {63'd0, rx_ovr}, 64'd0);
        chk("R8", "rx_vld clear+event", {63'd0, rx_vld}, 64'd1);
        clear(0);

        // R11: layout change mid-frame does not affect that frame
        cur_req = "R11";
        fork
            send(1, 16'h88F7, 8'h00, 8'h09, 40, 3, 4'h5, -1, t0);
            begin repeat (12) @(negedge clk); mode_we = 1'b1; mode_wd = 2'b00;
                  @(negedge clk); mode_we = 1'b0; end
        join
        chk("R11", "tx_stamp decoded with frame layout", tx_stamp, t0);
        clear(1);

        // R6 + R10: all-frames mode, both directions at once
        cur_req = "R6";
        set_mode(2'b10);
        fork
            send(0, 16'h0800, 8'h44, 8'h44, 16, 5, 4'h5, -1, t1);
            begin @(negedge clk); send(1, 16'h86DD, 8'h11, 8'h11, 16, 3, 4'h5, -1, t2); end
        join
        chk("R6", "rx_stamp all frames", rx_stamp, t1);
        chk("R10", "tx_stamp independent", tx_stamp, t2);
        chk("R10", "tx_vld independent", {63'd0, tx_vld}, 64'd1);
        clear(0); clear(1);
        set_mode(2'b11);
        send(1, 16'h1234, 8'h00, 8'h00, 4, 2, 4'h5, -1, t1);
        chk("R6", "tx_stamp mode 3", tx_stamp, t1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL %s watchdog got timeout expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule